// File: doc/BRIEF.md
# Tiled Halo Stream Address Generator

This block walks a large three-dimensional volume one tile at a time, so that a downstream stencil engine only ever needs line and plane buffers sized for a tile rather than for the whole volume. For every tile it emits the linear memory addresses of the tile's input region, halo included, one address per accepted transfer. The volume is stored row-major: x is the contiguous axis, a y step moves one row and a z step moves one plane. Alongside each address it marks the first and final address of the tile, and it flags the points whose stencil result is a real output.

Software-free operation: the volume extents, tile extents and the total stencil reach per axis are presented on plain inputs and captured when a one-cycle start pulse is accepted in the idle state. Each tile begins with a fixed number of setup cycles in which the base address is formed and nothing is issued. The address stream uses valid/ready. Once `addr_valid` is high, it stays high and `addr` and all point flags stay unchanged until `addr_ready` is sampled high. The consumer may hold `addr_ready` low for any number of cycles and may also raise it before valid appears. A transfer occurs on every rising clock edge at which both are high.

Top module: `blk3d_halo_addrgen`

## Requirements
- R1: After reset, `addr_valid` and `done` are low and stay low until a start pulse is accepted.
- R2: Tile origins step by the tile extents, x fastest, then y, then z, while the origin is below the volume extent. With lo = floor(reach/2) and hi = reach - lo, a tile at origin o with extent t streams, per axis, the points from max(o - lo, 0) up to min(o + t + hi, volume extent) - 1.
- R3: Within a tile, points go x fastest, then y, then z. Each address equals z*VX*VY + y*VX + x, where VX and VY are the volume extents.
- R4: `addr_valid` is low for exactly SETUP_CYC cycles after an accepted start and after the final transfer of every tile except the last. After that it rises.
- R5: The stream advances only on a transfer. While `addr_valid` is high and `addr_ready` is low, `addr`, `tile_first`, `tile_last` and `interior` hold their values.
- R6: `tile_first` is high on exactly the first address of each tile. `tile_last` is high on exactly its final address.
- R7: `interior` is high when, on each of the three axes, the point is at least lo positions from the start of the tile's clipped region and at least lo positions before its end. Here "before its end" means index + lo < the exclusive end.
- R8: `done` goes high in the cycle after the final transfer of the last tile. It stays high, with `addr_valid` low, until the next accepted start clears it.
- R9: A start pulse is ignored while a run is in progress. The address sequence continues unchanged.
- R10: Every issued address is below VX*VY*VZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| vol_x | input | DIM_W | Volume extent along x (row length) |
| vol_y | input | DIM_W | Volume extent along y (rows per plane) |
| vol_z | input | DIM_W | Volume extent along z (planes) |
| tile_x | input | DIM_W | Output tile extent along x |
| tile_y | input | DIM_W | Output tile extent along y |
| tile_z | input | DIM_W | Output tile extent along z |
| reach | input | DIM_W | Total stencil reach per axis |
| addr_valid | output | 1 | Address stream valid |
| addr_ready | input | 1 | Address stream ready from consumer |
| addr | output | ADDR_W | Linear row-major element address |
| tile_first | output | 1 | First address of a tile |
| tile_last | output | 1 | Final address of a tile |
| interior | output | 1 | Point yields an output of the tile |
| done | output | 1 | All tiles streamed |

## Verification
A wrong point counter or a wrong address accumulator shows up at the port as an address mismatch on the very transfer where it goes wrong. A broken wrap shows up at the first row or plane boundary of a tile. Because the reference is compared on every clock, a flag that drifts during back-pressure is caught in the stalled cycle itself. A wrong tile origin or a wrong clipping rule appears at the first address of the affected tile. A miscounted setup phase changes the number of idle cycles before that first address. An early or late `done`, or a start pulse that restarts the run when it should not, breaks the queue of expected transfers within one cycle.

// File: rtl/blk3d_pkg.sv
package blk3d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STREAM = 2'd2
  } gen_state_e;

  localparam int unsigned AXES = 3;
endpackage

// File: rtl/blk3d_axis_span.sv
module blk3d_axis_span #(
  parameter int unsigned DIM_W = 10
) (
  input  logic [DIM_W-1:0] origin,
  input  logic [DIM_W-1:0] tsize,
  input  logic [DIM_W-1:0] reach,
  input  logic [DIM_W-1:0] vol,
  output logic [DIM_W-1:0] beg,
  output logic [DIM_W-1:0] last,
  output logic [DIM_W:0]   core_beg,
  output logic [DIM_W:0]   core_end
);
  localparam int unsigned WW = DIM_W + 2;

  logic [WW-1:0] pad_lo, pad_hi, o_w, end_raw, end_clip, beg_w;

  always_comb begin
    pad_lo   = WW'(reach >> 1);
    pad_hi   = WW'(reach) - pad_lo;
    o_w      = WW'(origin);
    beg_w    = (o_w >= pad_lo) ? (o_w - pad_lo) : '0;
    end_raw  = o_w + WW'(tsize) + pad_hi;
    end_clip = (end_raw > WW'(vol)) ? WW'(vol) : end_raw;
    beg      = beg_w[DIM_W-1:0];
    last     = DIM_W'(end_clip - WW'(1));
    core_beg = (DIM_W+1)'(beg_w + pad_lo);
    core_end = (end_clip >= pad_lo) ? (DIM_W+1)'(end_clip - pad_lo) : '0;
  end
endmodule

// File: rtl/blk3d_tile_walk.sv
module blk3d_tile_walk #(
  parameter int unsigned DIM_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  step,
  input  logic [2:0][DIM_W-1:0] tsize,
  input  logic [2:0][DIM_W-1:0] vol,
  output logic [2:0][DIM_W-1:0] org,
  output logic                  is_last
);
  logic [3:0] carry;
  logic [2:0] wrap;
  logic [2:0][DIM_W-1:0] org_nx;

  always_comb begin
    carry[0] = 1'b1;
    for (int a = 0; a < 3; a++) begin
      wrap[a]    = ({1'b0, org[a]} + {1'b0, tsize[a]}) >= {1'b0, vol[a]};
      carry[a+1] = carry[a] & wrap[a];
      org_nx[a]  = wrap[a] ? '0 : org[a] + tsize[a];
    end
    is_last = carry[3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      org <= '0;
    end else if (step) begin
      for (int a = 0; a < 3; a++)
        if (carry[a]) org[a] <= org_nx[a];
    end
  end
endmodule

// File: rtl/blk3d_point_walk.sv
module blk3d_point_walk #(
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned ADDR_W = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic [2:0][DIM_W-1:0] beg,
  input  logic [2:0][DIM_W-1:0] last,
  input  logic [ADDR_W-1:0]     base,
  input  logic [ADDR_W-1:0]     row_stride,
  input  logic [ADDR_W-1:0]     plane_stride,
  output logic [2:0][DIM_W-1:0] pos,
  output logic [ADDR_W-1:0]     addr,
  output logic                  is_first,
  output logic                  is_last
);
  logic [3:0] carry;
  logic [2:0] wrap;
  logic [ADDR_W-1:0] row_base, pln_base;

  always_comb begin
    carry[0] = 1'b1;
    for (int a = 0; a < 3; a++) begin
      wrap[a]    = (pos[a] == last[a]);
      carry[a+1] = carry[a] & wrap[a];
    end
    is_last = carry[3];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      addr     <= '0;
      row_base <= '0;
      pln_base <= '0;
      is_first <= 1'b0;
    end else if (load) begin
      pos      <= beg;
      addr     <= base;
      row_base <= base;
      pln_base <= base;
      is_first <= 1'b1;
    end else if (step) begin
      is_first <= 1'b0;
      for (int a = 0; a < 3; a++)
        if (carry[a]) pos[a] <= wrap[a] ? beg[a] : pos[a] + 1'b1;
      if (!wrap[0]) begin
        addr <= addr + 1'b1;
      end else if (!wrap[1]) begin
        addr     <= row_base + row_stride;
        row_base <= row_base + row_stride;
      end else begin
        addr     <= pln_base + plane_stride;
        row_base <= pln_base + plane_stride;
        pln_base <= pln_base + plane_stride;
      end
    end
  end
endmodule

// File: rtl/blk3d_halo_addrgen.sv
module blk3d_halo_addrgen
  import blk3d_pkg::*;
#(
  parameter int unsigned DIM_W     = 10,
  parameter int unsigned ADDR_W    = 30,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  vol_x,
  input  logic [DIM_W-1:0]  vol_y,
  input  logic [DIM_W-1:0]  vol_z,
  input  logic [DIM_W-1:0]  tile_x,
  input  logic [DIM_W-1:0]  tile_y,
  input  logic [DIM_W-1:0]  tile_z,
  input  logic [DIM_W-1:0]  reach,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              tile_first,
  output logic              tile_last,
  output logic              interior,
  output logic              done
);
  localparam int unsigned SETUP_N = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int unsigned SCNT_W  = $clog2(SETUP_N + 1);
  localparam logic [SCNT_W-1:0] SCNT_END = SCNT_W'(SETUP_N - 1);

  gen_state_e state;
  logic [SCNT_W-1:0] scnt;
  logic [2:0][DIM_W-1:0] vol_q, tile_q;
  logic [DIM_W-1:0] reach_q;
  logic [ADDR_W-1:0] plane_q;

  logic [2:0][DIM_W-1:0] org, sp_beg, sp_last, pos;
  logic [2:0][DIM_W:0]   sp_cbeg, sp_cend;
  logic [2:0]            in_core;
  logic tile_is_last, pt_last, pt_first;
  logic [ADDR_W-1:0] base_addr, pw_addr;

  logic xfer, setup_end, tile_clear, tile_step, pt_load, pt_step;

  assign xfer       = (state == ST_STREAM) && addr_ready;
  assign setup_end  = (state == ST_SETUP) && (scnt == SCNT_END);
  assign tile_clear = (state == ST_IDLE) && start;
  assign tile_step  = xfer && pt_last && !tile_is_last;
  assign pt_load    = setup_end;
  assign pt_step    = xfer && !pt_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      scnt    <= '0;
      done    <= 1'b0;
      vol_q   <= '0;
      tile_q  <= '0;
      reach_q <= '0;
      plane_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          vol_q   <= {vol_z, vol_y, vol_x};
          tile_q  <= {tile_z, tile_y, tile_x};
          reach_q <= reach;
          plane_q <= ADDR_W'(vol_x) * ADDR_W'(vol_y);
          done    <= 1'b0;
          scnt    <= '0;
          state   <= ST_SETUP;
        end
        ST_SETUP: begin
          scnt <= scnt + 1'b1;
          if (setup_end) state <= ST_STREAM;
        end
        ST_STREAM: if (xfer && pt_last) begin
          scnt <= '0;
          if (tile_is_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_SETUP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  blk3d_tile_walk #(.DIM_W(DIM_W)) u_tiles (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tile_clear),
    .step    (tile_step),
    .tsize   (tile_q),
    .vol     (vol_q),
    .org     (org),
    .is_last (tile_is_last)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    blk3d_axis_span #(.DIM_W(DIM_W)) u_span (
      .origin   (org[a]),
      .tsize    (tile_q[a]),
      .reach    (reach_q),
      .vol      (vol_q[a]),
      .beg      (sp_beg[a]),
      .last     (sp_last[a]),
      .core_beg (sp_cbeg[a]),
      .core_end (sp_cend[a])
    );
    assign in_core[a] = ({1'b0, pos[a]} >= sp_cbeg[a]) && ({1'b0, pos[a]} < sp_cend[a]);
  end

  assign base_addr = ADDR_W'(sp_beg[2]) * plane_q
                   + ADDR_W'(sp_beg[1]) * ADDR_W'(vol_q[1-1])
                   + ADDR_W'(sp_beg[0]);

  blk3d_point_walk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_points (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (pt_load),
    .step         (pt_step),
    .beg          (sp_beg),
    .last         (sp_last),
    .base         (base_addr),
    .row_stride   (ADDR_W'(vol_q[0])),
    .plane_stride (plane_q),
    .pos          (pos),
    .addr         (pw_addr),
    .is_first     (pt_first),
    .is_last      (pt_last)
  );

  assign addr_valid = (state == ST_STREAM);
  assign addr       = pw_addr;
  assign tile_first = addr_valid && pt_first;
  assign tile_last  = addr_valid && pt_last;
  assign interior   = addr_valid && (&in_core);
endmodule

// File: rtl/blk3d_halo_addrgen_chk.sv
module blk3d_halo_addrgen_chk #(
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned ADDR_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIM_W-1:0]  vol_x,
  input logic [DIM_W-1:0]  vol_y,
  input logic [DIM_W-1:0]  vol_z,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic              tile_first,
  input logic              tile_last,
  input logic              interior,
  input logic              done
);
  logic [ADDR_W-1:0] vol_cells;
  assign vol_cells = ADDR_W'(vol_x) * ADDR_W'(vol_y) * ADDR_W'(vol_z);

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(tile_first)
      && $stable(tile_last) && $stable(interior)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid); // R8

  AST_GAP_AFTER_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && tile_last |=> !addr_valid); // R4

  AST_FIRST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> tile_first); // R6

  AST_ADDR_IN_VOLUME: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr < vol_cells); // R10
endmodule

bind blk3d_halo_addrgen blk3d_halo_addrgen_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_blk3d_halo_addrgen.sv
module tb_blk3d_halo_addrgen;
  localparam int DIM_W = 10;
  localparam int ADDR_W = 30;
  localparam int SETUP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] vol_x = '0, vol_y = '0, vol_z = '0;
  logic [DIM_W-1:0] tile_x = '0, tile_y = '0, tile_z = '0, reach = '0;
  logic addr_valid, addr_ready = 1'b0, tile_first, tile_last, interior, done;
  logic [ADDR_W-1:0] addr;

  always #2 clk = ~clk;

  blk3d_halo_addrgen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .SETUP_CYC(SETUP)) dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int q_addr[$];
  int q_flag[$];
  bit armed = 0, want_done = 0, want_clr = 0, req_start = 0, req_busy = 0, rnd_ready = 0, live = 0;
  int gap = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(int a, int b); return a > b ? a : b; endfunction
  function automatic int imin(int a, int b); return a < b ? a : b; endfunction

  // Nested-loop model of the full stream (R2, R3, R6, R7)
  task automatic build(input int vx, vy, vz, tx, ty, tz, ns);
    int lo, hi;
    lo = ns / 2; hi = ns - lo;
    for (int oz = 0; oz < vz; oz += tz)
      for (int oy = 0; oy < vy; oy += ty)
        for (int ox = 0; ox < vx; ox += tx) begin
          int bx, ex, by, ey, bz, ez;
          bit first;
          bx = imax(ox - lo, 0); ex = imin(ox + tx + hi, vx);
          by = imax(oy - lo, 0); ey = imin(oy + ty + hi, vy);
          bz = imax(oz - lo, 0); ez = imin(oz + tz + hi, vz);
          first = 1;
          for (int z = bz; z < ez; z++)
            for (int y = by; y < ey; y++)
              for (int x = bx; x < ex; x++) begin
                bit inr;
                inr = (x >= bx + lo) && (x + lo < ex) && (y >= by + lo) && (y + lo < ey)
                      && (z >= bz + lo) && (z + lo < ez);
                q_addr.push_back(z * vx * vy + y * vx + x);
                q_flag.push_back({inr, 1'b0, first});
                first = 0;
              end
          q_flag[q_flag.size()-1] = q_flag[q_flag.size()-1] | 2;
        end
  endtask

  always @(negedge clk) begin
    bit r;
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (live) begin
      if (want_clr) begin
        check(done == 1'b0, "R8 done cleared by start", done, 0);
        want_clr = 0;
      end
      if (armed) begin
        if (!addr_valid) gap++;
        else begin
          check(gap == SETUP, "R4 setup gap", gap, SETUP);
          armed = 0;
        end
      end
      if (want_done) begin
        check(done == 1'b1 && !addr_valid, "R8 done after final transfer", done, 1);
        want_done = 0;
      end
      if (addr_valid) begin
        if (q_addr.size() == 0) check(0, "R9 unexpected address", addr, -1);
        else begin
          check(addr == q_addr[0], "R3 address", addr, q_addr[0]);
          check({interior, tile_last, tile_first} == q_flag[0][2:0], "R6 R7 flags",
                {interior, tile_last, tile_first}, q_flag[0]);
        end
      end
      r = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      addr_ready = r;
      if (addr_valid && r && q_addr.size() > 0) begin
        int f;
        f = q_flag[0];
        void'(q_addr.pop_front());
        void'(q_flag.pop_front());
        if (f & 2) begin
          if (q_addr.size() == 0) want_done = 1;
          else begin armed = 1; gap = 0; end
        end
      end
    end
    if (req_start) begin
      start = 1; req_start = 0; armed = 1; gap = 0; want_clr = 1;
    end else if (req_busy) begin
      start = 1; req_busy = 0;
    end else start = 0;
  end

  task automatic run(input int vx, vy, vz, tx, ty, tz, ns, input bit rnd, input bit poke);
    @(posedge clk);
    vol_x = DIM_W'(vx); vol_y = DIM_W'(vy); vol_z = DIM_W'(vz);
    tile_x = DIM_W'(tx); tile_y = DIM_W'(ty); tile_z = DIM_W'(tz); reach = DIM_W'(ns);
    rnd_ready = rnd;
    build(vx, vy, vz, tx, ty, tz, ns);
    live = 1;
    req_start = 1;
    if (poke) begin
      repeat (SETUP + 12) @(posedge clk);
      req_busy = 1; // R9: pulse while busy
    end
    while (!(done && q_addr.size() == 0)) @(posedge clk);
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1;
    check(done == 1'b1, "R8 done holds", done, 1);
    check(addr_valid == 1'b0, "R8 idle after run", addr_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(addr_valid == 1'b0, "R1 reset valid", addr_valid, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check(addr_valid == 1'b0 && done == 1'b0, "R1 idle before start", {addr_valid, done}, 0);
    run(7, 5, 4, 3, 2, 3, 2, 1, 1);
    run(6, 4, 3, 4, 4, 2, 3, 0, 0);
    run(3, 3, 2, 8, 8, 8, 0, 1, 0);
    run(5, 6, 2, 2, 3, 1, 4, 1, 1);
    check(q_addr.size() == 0, "R2 all tiles streamed", q_addr.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule